// File: doc/BRIEF.md
# High-Side Over-Current Protection Controller

This block is the digital guard for a small group of output pins that can source enough current to act as switched supplies for external loads such as sensors. Each pin has its own configuration: a protection enable, a strong-drive select, a direction bit and an output data bit. An analog comparator per pin reports when the sourced current is too high. The block brings that comparator signal into the clock domain and qualifies it against the pin's configuration and the chip's stop-mode state. A qualified event pulls the pin's output data low at once.

A qualified event also latches a per-pin sticky fault flag. While the flag is set, the pin stays forced low whatever its data bit says. Software releases the pin by writing a one to the flag's bit. An interrupt enable per pin feeds a single registered interrupt request. Analog sensing and the pad itself sit outside this block.

Top module: `ocp_ctrl`

## Requirements
- R1: After reset every fault flag reads 0, the interrupt request reads 0, and each pin output equals its data bit.
- R2: The comparator input passes through a two-stage synchronizer. An over-current level that is present at rising edge k forces the pin output low from just after edge k+1, and sets the pin's fault flag at edge k+2.
- R3: A comparator assertion is honoured only when the pin's protection enable, strong-drive select and direction bit (1 = output) are all 1. Otherwise it changes neither the flag nor the output.
- R4: Only the high side is protected. While the pin's data bit is 0, the comparator input is ignored.
- R5: While stop_mode is 1, the comparator inputs are ignored and no flag is set.
- R6: While a pin's fault flag is 1, its output is 0 regardless of its data bit, even after the comparator input has returned to 0.
- R7: A flag bit is cleared at a rising edge where clr_we is 1 and the matching clr_data bit is 1. A 0 in clr_data leaves the flag unchanged. Once the flag is cleared and no new event is present, the output again follows its data bit.
- R8: If a qualified event and a clear of the same pin's flag fall on the same edge, the flag stays 1.
- R9: Clearing a pin's protection enable keeps an already-set flag and the forced-low output, but blocks new events.
- R10: irq is a register that takes, at each rising edge, the OR over pins of (flag AND irq_en), so it follows a flag change one cycle late.
- R11: Pins are independent: an event, configuration or clear on one pin does not affect another pin's flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_mode | input | 1 | Chip in stop mode; monitoring suspended |
| prot_en | input | N_PINS | Per-pin protection enable |
| full_drv | input | N_PINS | Per-pin strong-drive select |
| dir_out | input | N_PINS | Per-pin direction, 1 = output |
| out_data | input | N_PINS | Per-pin output data bit |
| ocd_in | input | N_PINS | Asynchronous over-current comparator outputs |
| irq_en | input | N_PINS | Per-pin interrupt enable |
| clr_we | input | 1 | Flag write strobe |
| clr_data | input | N_PINS | Write-one-to-clear data for the flags |
| pin_out | output | N_PINS | Output data after the protection override |
| ocif | output | N_PINS | Sticky over-current fault flags |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach is a clear that lands on the same edge as a fresh qualified event. The comparator input has to be raised exactly two cycles before the clear write while every qualifier is held at 1. A directed sequence schedules this case. Random stimulus then keeps the qualifiers mostly enabled and mixes frequent clears with comparator pulses, so this collision and the stop-mode and disabled-pin cases also come up in many other alignments.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // An over-current report counts only when the pin is protected, strongly
  // driven, configured as an output, sourcing (data high) and not stopped.
  function automatic logic ocp_qualify(input logic ocd_s,
                                       input logic en,
                                       input logic full,
                                       input logic dir,
                                       input logic data,
                                       input logic stop);
    return ocd_s & en & full & dir & data & ~stop;
  endfunction

  // Next value of a sticky flag: a new event wins over a clear.
  function automatic logic ocp_flag_next(input logic cur,
                                         input logic evt,
                                         input logic clr);
    return evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/ocp_pin_monitor.sv
module ocp_pin_monitor
  import ocp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ocd_s,
  input  logic en,
  input  logic full,
  input  logic dir,
  input  logic data,
  input  logic stop,
  input  logic clr,
  output logic det,
  output logic flag,
  output logic pin
);
  logic flag_q;

  assign det = ocp_qualify(ocd_s, en, full, dir, data, stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= ocp_flag_next(flag_q, det, clr);
  end

  assign flag = flag_q;
  // Force low in the detection cycle itself and for as long as the flag holds.
  assign pin  = data & ~(flag_q | det);
endmodule

// File: rtl/ocp_irq.sv
module ocp_irq #(
  parameter int N_PINS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] flag,
  input  logic [N_PINS-1:0] en,
  output logic              irq
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flag & en);
  end

  assign irq = irq_q;
endmodule

// File: rtl/ocp_ctrl.sv
module ocp_ctrl #(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_mode,
  input  logic [N_PINS-1:0] prot_en,
  input  logic [N_PINS-1:0] full_drv,
  input  logic [N_PINS-1:0] dir_out,
  input  logic [N_PINS-1:0] out_data,
  input  logic [N_PINS-1:0] ocd_in,
  input  logic [N_PINS-1:0] irq_en,
  input  logic              clr_we,
  input  logic [N_PINS-1:0] clr_data,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] ocif,
  output logic              irq
);
  logic [N_PINS-1:0] ocd_sync;
  logic [N_PINS-1:0] det_evt;
  logic [N_PINS-1:0] clr_hit;

  assign clr_hit = clr_data & {N_PINS{clr_we}};

  ocp_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (ocd_in),
    .d_out (ocd_sync)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    ocp_pin_monitor i_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .ocd_s (ocd_sync[p]),
      .en    (prot_en[p]),
      .full  (full_drv[p]),
      .dir   (dir_out[p]),
      .data  (out_data[p]),
      .stop  (stop_mode),
      .clr   (clr_hit[p]),
      .det   (det_evt[p]),
      .flag  (ocif[p]),
      .pin   (pin_out[p])
    );
  end

  ocp_irq #(.N_PINS(N_PINS)) i_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flag  (ocif),
    .en    (irq_en),
    .irq   (irq)
  );
endmodule

// File: rtl/ocp_ctrl_chk.sv
module ocp_ctrl_chk #(
  parameter int N_PINS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_mode,
  input logic [N_PINS-1:0] prot_en,
  input logic [N_PINS-1:0] full_drv,
  input logic [N_PINS-1:0] dir_out,
  input logic [N_PINS-1:0] out_data,
  input logic [N_PINS-1:0] irq_en,
  input logic [N_PINS-1:0] clr_hit,
  input logic [N_PINS-1:0] det_evt,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] ocif,
  input logic              irq
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_chk
    AST_QUALIFIED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      det_evt[p] |-> (prot_en[p] && full_drv[p] && dir_out[p])); // R3
    AST_HIGH_SIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !out_data[p] |-> !det_evt[p]); // R4
    AST_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_mode |-> !det_evt[p]); // R5
    AST_FLAG_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ocif[p] |-> !pin_out[p]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ocif[p] && !clr_hit[p]) |=> ocif[p]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      det_evt[p] |=> ocif[p]); // R8
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((ocif & irq_en) == '0) |=> !irq); // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ocif & irq_en) != '0) |=> irq); // R10
endmodule

bind ocp_ctrl ocp_ctrl_chk #(.N_PINS(N_PINS)) i_ocp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_mode (stop_mode),
  .prot_en   (prot_en),
  .full_drv  (full_drv),
  .dir_out   (dir_out),
  .out_data  (out_data),
  .irq_en    (irq_en),
  .clr_hit   (clr_hit),
  .det_evt   (det_evt),
  .pin_out   (pin_out),
  .ocif      (ocif),
  .irq       (irq)
);

// File: tb/test_ocp_ctrl.sv
`timescale 1ns/1ps
module test_ocp_ctrl;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_mode = 1'b0;
  logic [NP-1:0] prot_en = '0, full_drv = '0, dir_out = '0, out_data = '0;
  logic [NP-1:0] ocd_in = '0, irq_en = '0, clr_data = '0;
  logic          clr_we = 1'b0;
  logic [NP-1:0] pin_out, ocif;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  ocp_ctrl #(.N_PINS(NP)) i_ocp_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .prot_en(prot_en),
    .full_drv(full_drv), .dir_out(dir_out), .out_data(out_data),
    .ocd_in(ocd_in), .irq_en(irq_en), .clr_we(clr_we), .clr_data(clr_data),
    .pin_out(pin_out), .ocif(ocif), .irq(irq)
  );

  always #10 clk = ~clk;

  // Reference model built from the requirements.
  logic [NP-1:0] m_s1, m_s2, m_flag;
  logic          m_irq;

  function automatic logic [NP-1:0] m_event(input logic [NP-1:0] s2);
    if (stop_mode) return '0;                                     // R5
    return s2 & prot_en & full_drv & dir_out & out_data;          // R3 R4
  endfunction

  function automatic logic [NP-1:0] m_pins();
    return out_data & ~(m_flag | m_event(m_s2));                  // R6
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_flag <= '0; m_irq <= 1'b0;
    end else begin
      m_s1   <= ocd_in;
      m_s2   <= m_s1;
      m_flag <= m_event(m_s2) | (m_flag & ~(clr_data & {NP{clr_we}})); // R7 R8
      m_irq  <= |(m_flag & irq_en);                                 // R10
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic model_check(input string req);
    check(req, 32'(pin_out), 32'(m_pins()));
    check(req, 32'(ocif), 32'(m_flag));
    check(req, 32'(irq), 32'(m_irq));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    out_data = 2'b11;
    #35 rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 flags", 32'(ocif), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 pins", 32'(pin_out), 32'h3);

    // R3 not qualified: pin0 missing full drive
    prot_en = 2'b11; dir_out = 2'b11; full_drv = 2'b10; irq_en = 2'b01;
    ocd_in = 2'b01;
    repeat (4) step();
    check("R3 no flag", 32'(ocif), 0);
    check("R3 pin high", 32'(pin_out), 32'h3);
    ocd_in = 0; repeat (3) step();

    // R2 latency and R11 independence
    full_drv = 2'b11;
    ocd_in = 2'b01;
    step();                                       // edge k
    check("R2 pin after k", 32'(pin_out), 32'h3);
    step();                                       // edge k+1
    check("R2 pin forced after k+1", 32'(pin_out), 32'h2);
    check("R2 flag not yet", 32'(ocif), 0);
    step();                                       // edge k+2
    check("R2 flag at k+2", 32'(ocif), 32'h1);
    check("R10 irq lags", 32'(irq), 0);
    ocd_in = 0;
    step();
    check("R10 irq set", 32'(irq), 1);
    check("R11 pin1 untouched", 32'(pin_out[1]), 1);
    repeat (3) step();
    check("R6 held low", 32'(pin_out), 32'h2);

    // R9 disable keeps flag
    prot_en = 2'b10; step();
    check("R9 flag kept", 32'(ocif), 32'h1);
    ocd_in = 2'b01; repeat (3) step();
    // R7 write of zero has no effect
    clr_we = 1'b1; clr_data = 2'b10; step();
    check("R7 zero no effect", 32'(ocif), 32'h1);
    // R9 clear with enable off: no new event even with ocd high
    clr_data = 2'b01; step();
    clr_we = 1'b0; clr_data = 0;
    check("R7 cleared", 32'(ocif), 0);
    check("R7 pin resumes", 32'(pin_out), 32'h3);
    step();
    check("R9 blocked", 32'(ocif), 0);

    // R8 set wins over clear on the same edge
    prot_en = 2'b11; ocd_in = 2'b01;
    step(); step();                               // det now active
    clr_we = 1'b1; clr_data = 2'b01; step();
    check("R8 set wins", 32'(ocif), 32'h1);
    clr_we = 1'b0; clr_data = 0; ocd_in = 0;
    repeat (3) step();
    clr_we = 1'b1; clr_data = 2'b01; step(); clr_we = 1'b0; clr_data = 0;

    // R4 data low ignored; R5 stop ignored
    out_data = 2'b10; ocd_in = 2'b11; stop_mode = 1'b1;
    repeat (4) step();
    check("R5 stop ignores pin1", 32'(ocif[1]), 0);
    check("R4 low side pin0", 32'(ocif[0]), 0);
    stop_mode = 1'b0; repeat (2) step();
    check("R4 still none pin0", 32'(ocif[0]), 0);
    check("R11 pin1 flagged", 32'(ocif[1]), 1);
    ocd_in = 0; out_data = 2'b11;
    repeat (3) step();
    clr_we = 1'b1; clr_data = 2'b11; step(); clr_we = 1'b0; clr_data = 0;
    step();

    // Random mix against the model
    for (int i = 0; i < 3000; i++) begin
      prot_en   = {($urandom % 4) != 0, ($urandom % 4) != 0};
      full_drv  = {($urandom % 5) != 0, ($urandom % 5) != 0};
      dir_out   = {($urandom % 5) != 0, ($urandom % 5) != 0};
      out_data  = {($urandom % 3) != 0, ($urandom % 3) != 0};
      ocd_in    = {($urandom % 3) == 0, ($urandom % 3) == 0};
      irq_en    = NP'($urandom);
      stop_mode = ($urandom % 8) == 0;
      clr_we    = ($urandom % 4) == 0;
      clr_data  = NP'($urandom);
      step();
      model_check("R2-model");
    end
    summary();
  end
endmodule